// File: doc/BRIEF.md
# Byte-RAM Serial Bit Delay Line

This block delays a one-bit sample stream, such as the output of a 1-bit delta-sigma modulator, by a long and selectable number of clock cycles. Every clock edge takes one input bit and produces one delayed output bit. The stream is stored in a byte-wide RAM rather than a flip-flop chain. Each word holds eight stream bits in flight. An address counter visits every word once per lap. On each visit the word is read, shifted down one place with the newest bit entering at the top, and written back. The bit that falls off the bottom is the delayed output. A bit therefore leaves after eight laps, so the delay is the word width times the counter modulus.

The modulus is a power of two chosen from a set of delay-select lines. Select line i gives 2^(MIN_AW+i) words. With no line asserted, the longest modulus 2^(MIN_AW+NSEL) is used. When the selection changes, the counter restarts at word zero. The output is then stale until one full new delay has elapsed. At full size (MIN_AW=6, NSEL=8) the nine settings range from 64 to 16384 words, which is 512 to 131072 cycles of delay. The defaults are smaller so that the array stays modest.

Top module: `bitram_delay`

## Requirements
- R1: After the clock edge numbered n, `dout` equals the `din` value sampled at edge n − 8·2^AW, where AW is the active address width. The input edge must lie in the current epoch: at or after the first edge following reset or a selection change.
- R2: When select line i is the lowest asserted line, AW = MIN_AW + i. For example, line 0 alone gives a delay of 8·2^MIN_AW cycles.
- R3: When no select line is asserted, AW = MIN_AW + NSEL, which is the longest delay.
- R4: When several select lines are asserted, the lowest-numbered one alone sets AW.
- R5: A change of the decoded setting returns the word address to zero at that edge. From the next edge onward, R1 holds for the new AW.
- R6: While `rst` is high at a clock edge, `dout` is 0 after that edge and the word address returns to zero. R1 then holds from the first edge after reset.
- R7: The word address never exceeds 2^AW − 1. Within a setting, it either steps by one or wraps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one read-modify-write per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Incoming stream bit, sampled on the rising edge |
| sel | input | NSEL | Delay-select lines; lowest asserted line wins, none gives the longest delay |
| dout | output | 1 | Registered delayed stream bit |

## Verification
A wrong word address or a wrong wrap limit does not show up right away. It appears exactly one delay period later, when the misplaced bits reach `dout`: too early, too late, or scrambled. For that reason, the bench compares every output bit against a reference shift line once the first full delay after each reset or setting change has elapsed. A wrong priority decode or a missed counter restart shifts the whole output sequence. Each such setting is run long enough for that shift to become visible as bit mismatches.

// File: rtl/dly_pkg.sv
package dly_pkg;
  // Highest word index for an address counter of the given width.
  function automatic logic [31:0] wrap_last(input int aw);
    return (32'd1 << aw) - 32'd1;
  endfunction
endpackage

// File: rtl/dly_sel_decode.sv
module dly_sel_decode #(
  parameter int NSEL = 6,
  parameter int LW   = $clog2(NSEL + 1)
) (
  input  logic [NSEL-1:0] sel,
  output logic [LW-1:0]   len
);
  // Lowest asserted line wins; none asserted picks the longest setting.
  always_comb begin
    len = LW'(NSEL);
    for (int i = NSEL - 1; i >= 0; i--) begin
      if (sel[i]) len = LW'(i);
    end
  end
endmodule

// File: rtl/dly_addr_ctr.sv
module dly_addr_ctr #(
  parameter int MIN_AW = 3,
  parameter int NSEL   = 6,
  parameter int MAX_AW = MIN_AW + NSEL,
  parameter int LW     = $clog2(NSEL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LW-1:0]     len_d,
  output logic [LW-1:0]     len_q,
  output logic [MAX_AW-1:0] addr,
  output logic [MAX_AW-1:0] addr_nxt
);
  localparam logic [MAX_AW-1:0] ONE = MAX_AW'(1);

  logic [MAX_AW-1:0] last;

  always_comb begin
    last = MAX_AW'(dly_pkg::wrap_last(MIN_AW + int'(len_q)));
    if (rst || (len_d != len_q))
      addr_nxt = '0;
    else if (addr == last)
      addr_nxt = '0;
    else
      addr_nxt = addr + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      len_q <= len_d;
    end else begin
      addr  <= addr_nxt;
      len_q <= len_d;
    end
  end
endmodule

// File: rtl/dly_byte_ram.sv
module dly_byte_ram #(
  parameter int AW    = 9,
  parameter int W     = 8,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  // Simple dual-port with registered read, suitable for block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/bitram_delay.sv
module bitram_delay #(
  parameter int MIN_AW = 3,
  parameter int NSEL   = 6,
  parameter int WORD_W = 8,
  parameter int MAX_AW = MIN_AW + NSEL,
  parameter int LW     = $clog2(NSEL + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            din,
  input  logic [NSEL-1:0] sel,
  output logic            dout
);
  logic [LW-1:0]     len_d;
  logic [LW-1:0]     len_q;
  logic [MAX_AW-1:0] addr;
  logic [MAX_AW-1:0] addr_nxt;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] wr_word;

  dly_sel_decode #(.NSEL(NSEL), .LW(LW)) u_dec (
    .sel (sel),
    .len (len_d)
  );

  dly_addr_ctr #(.MIN_AW(MIN_AW), .NSEL(NSEL), .MAX_AW(MAX_AW), .LW(LW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .len_d    (len_d),
    .len_q    (len_q),
    .addr     (addr),
    .addr_nxt (addr_nxt)
  );

  // The read is issued one cycle ahead, so rd_word holds the current word.
  assign wr_word = {din, rd_word[WORD_W-1:1]};

  dly_byte_ram #(.AW(MAX_AW), .W(WORD_W)) u_ram (
    .clk (clk),
    .we  (!rst),
    .wa  (addr),
    .wd  (wr_word),
    .ra  (addr_nxt),
    .rd  (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= 1'b0;
    else     dout <= rd_word[0];
  end
endmodule

// File: rtl/bitram_delay_chk.sv
module bitram_delay_chk #(
  parameter int MIN_AW = 3,
  parameter int NSEL   = 6,
  parameter int MAX_AW = MIN_AW + NSEL,
  parameter int LW     = $clog2(NSEL + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [NSEL-1:0]   sel,
  input logic [MAX_AW-1:0] addr,
  input logic [LW-1:0]     len_q,
  input logic              dout
);
  localparam logic [MAX_AW-1:0] ONE = MAX_AW'(1);

  logic [MAX_AW-1:0] lim;
  assign lim = MAX_AW'(dly_pkg::wrap_last(MIN_AW + int'(len_q)));

  p_addr_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    addr <= lim);

  p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && len_q == $past(len_q)) |-> (addr == '0 || addr == $past(addr) + ONE));

  p_restart_on_change_r5: assert property (@(posedge clk) disable iff (rst)
    (len_q != $past(len_q)) |-> addr == '0);

  p_reset_clears_r6: assert property (@(posedge clk)
    $past(rst) |-> (!dout && addr == '0));

  p_line0_wins_r4: assert property (@(posedge clk) disable iff (rst)
    $past(sel[0]) |-> len_q == '0);

  p_none_longest_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) == '0) |-> len_q == LW'(NSEL));
endmodule

bind bitram_delay bitram_delay_chk #(.MIN_AW(MIN_AW), .NSEL(NSEL), .MAX_AW(MAX_AW), .LW(LW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .sel   (sel),
  .addr  (addr),
  .len_q (len_q),
  .dout  (dout)
);

// File: tb/sim_bitram_delay.sv
module sim_bitram_delay;
  localparam int MIN_AW = 3;
  localparam int NSEL   = 6;
  localparam int WORD_W = 8;
  localparam int HSZ    = 8192;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            din = 1'b0;
  logic [NSEL-1:0] sel = '0;
  logic            dout;

  int    n_chk = 0;
  int    n_bad = 0;
  int    edge_n = 0;
  int    epoch = 1;
  int    dly = 0;
  bit    hist [HSZ];
  string tag = "R1";

  always #2 clk = ~clk;

  bitram_delay #(.MIN_AW(MIN_AW), .NSEL(NSEL), .WORD_W(WORD_W)) u0 (
    .clk (clk), .rst (rst), .din (din), .sel (sel), .dout (dout)
  );

  function automatic int exp_delay(input logic [NSEL-1:0] s);
    int aw;
    aw = MIN_AW + NSEL;
    for (int i = NSEL - 1; i >= 0; i--) if (s[i]) aw = MIN_AW + i;
    return WORD_W * (1 << aw);
  endfunction

  task automatic check(input string t, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s edge %0d: dout=%b expected %b", t, edge_n, act, exp);
    end
  endtask

  // Drive one bit, advance one edge, then compare against the reference line.
  task automatic step(input logic b);
    @(negedge clk);
    din = b;
    @(posedge clk);
    edge_n++;
    hist[edge_n % HSZ] = b;
    #1;
    if (rst) begin
      epoch = edge_n + 1;
      check("R6", dout, 1'b0);
    end else if (edge_n - dly >= epoch) begin
      check(tag, dout, hist[(edge_n - dly) % HSZ]);
    end
  endtask

  task automatic set_sel(input logic [NSEL-1:0] s, input string t);
    @(negedge clk);
    sel = s;
    tag = t;
    dly = exp_delay(s);
    @(posedge clk);
    edge_n++;
    hist[edge_n % HSZ] = din;
    epoch = edge_n + 1;
  endtask

  task automatic run(input int cycles, input int mode);
    for (int k = 0; k < cycles; k++) begin
      case (mode)
        0: step(1'($urandom));
        1: step(k[0]);
        2: step(1'b1);
        default: step((k % 5) == 0);
      endcase
    end
  endtask

  initial begin
    #800000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    dly = exp_delay(sel);
    // R6: reset state
    rst = 1'b1;
    run(3, 0);
    @(negedge clk);
    rst = 1'b0;
    // R3: no select line, longest delay
    tag = "R3";
    run(dly + 200, 0);
    // R2: line 0 alone, shortest delay
    set_sel(6'b000001, "R2");
    run(dly + 150, 1);
    run(150, 0);
    // R4: several lines, lowest (line 2) wins
    set_sel(6'b101100, "R4");
    run(dly + 300, 0);
    // R1: top line alone, constant then sparse pattern
    set_sel(6'b100000, "R1");
    run(dly / 2, 2);
    run(dly / 2 + 300, 3);
    // R6: reset mid-run, then restart on line 1
    set_sel(6'b000010, "R6");
    run(50, 0);
    @(negedge clk);
    rst = 1'b1;
    run(2, 0);
    @(negedge clk);
    rst = 1'b0;
    run(dly + 200, 1);
    // R5: random setting changes
    for (int j = 0; j < 8; j++) begin
      set_sel(NSEL'($urandom) & NSEL'($urandom), "R5");
      run(dly + 100, 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule